// File: doc/BRIEF.md
# Eight-Point Inverse Cosine Transform Core (Digit-Serial, Multiplierless)

This block computes a one-dimensional eight-point inverse discrete cosine transform. Coefficient words arrive one per cycle under a valid strobe, in coefficient index order 0 to 7. A finished block of eight output samples leaves one per cycle under its own valid strobe. Blocks may follow each other with no idle cycles, so the core sustains one output sample per clock.

The transform kernel is split in two. An even network takes coefficients 0, 2, 4 and 6 and forms the four symmetric half-sums. An odd network takes coefficients 1, 3, 5 and 7 and forms the four antisymmetric half-differences. Neither network uses a multiplier or a lookup table. Each one consumes the captured words two bits per cycle, most significant digit first. For every digit, the network adds constant-weighted copies of those bits and folds the sum into an accumulator with a two-place shift. Every kernel constant is prescaled by the square root of two. A butterfly then forms each sample as a sum or a difference of the two networks' results, rounds it to nearest and saturates it.

Because of the prescale, every output equals √2 times the true transform value. A second pass of the same kernel, run on transposed data, turns the total gain into a power of two.

Top module: `idct8_core`

## Requirements
- R1: While reset is high, and after it until the first complete block has been accepted, `out_valid` is 0 and `out_data` is 0.
- R2: A word is accepted only in a cycle where `in_valid` is 1. Cycles with `in_valid` at 0 are ignored, including cycles in the middle of a block. The n-th accepted word of a block (n = 0..7) is coefficient n.
- R3: Output sample n (n = 0..7, presented in that order on consecutive cycles) is within 1 LSB of √2·Σk ck/2·X[k]·cos((2n+1)kπ/16), where c0 = 1/√2 and ck = 1 otherwise. Words are two's complement, 12 bits in and 13 bits out.
- R4: A block of eight zero coefficients yields exactly eight zero samples.
- R5: A result outside the signed 13-bit range is clamped to +4095 or −4096.
- R6: Sample 0 of a block is valid in the cycle after the 7th rising edge that follows the edge accepting that block's last word.
- R7: When blocks arrive back to back, `out_valid` stays high with no gap, giving 8 samples every 8 cycles.
- R8: A block with nonzero coefficients only at even indices gives mirror-equal samples, with v[n] = v[7−n]. A block with nonzero coefficients only at odd indices gives mirror-negated samples, with |v[n] + v[7−n]| ≤ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Coefficient word present this cycle |
| in_data | input | 12 | Coefficient word, two's complement |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | 13 | Output sample, two's complement, √2-scaled |

## Verification
A wrong digit in one accumulator shows up as a sample that misses the floating-point model. The size of the miss depends on the digit's weight. A fault in the top digit moves the result by thousands of LSBs, while a fault in the last digit moves it by the kernel constant divided by 2^15. Either way it appears at the port seven cycles after the block's last word. A fault in the even or odd network breaks the mirror relations of R8 in that same block. A slipped word counter shifts every later block's coefficients, so every following sample fails. A fault in the output index or valid sequencing shows as a gap in the stream, or as a sample in the wrong position, within the first eight output cycles of the affected block.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int NPT       = 8;   // transform points
    localparam int HALF      = 4;   // points per kernel half
    localparam int COEF_FRAC = 14;  // fraction bits of the prescaled constants

    // one digit-plane of the captured block, broadcast to both networks
    typedef struct packed {
        logic                  valid;
        logic                  first;  // most significant (signed) digit
        logic                  last;   // least significant digit
        logic [NPT-1:0][1:0]   d;
    } slice_t;

    // sqrt(2)*cos(a*pi/16) in Q(COEF_FRAC), folded into the first quadrant
    function automatic int kern_w(int i, int n);
        int a;
        int w;
        bit neg;
        if (i == 0) return 16384;           // DC term: sqrt2 * (1/sqrt2) = 1
        a = ((2 * n + 1) * i) % 32;
        if (a > 16) a = 32 - a;
        neg = 1'b0;
        if (a > 8) begin
            a   = 16 - a;
            neg = 1'b1;
        end
        case (a)
            0:       w = 23170;
            1:       w = 22725;
            2:       w = 21407;
            3:       w = 19266;
            4:       w = 16384;
            5:       w = 12873;
            6:       w = 8867;
            7:       w = 4520;
            default: w = 0;
        endcase
        return neg ? -w : w;
    endfunction

    // weight of one 2-bit digit; the leading digit's upper bit counts negative
    function automatic int digit_term(logic [1:0] b, logic msd, int w);
        int t;
        t = 0;
        if (b[0]) t = t + w;
        if (b[1]) t = msd ? t - 2 * w : t + 2 * w;
        return t;
    endfunction

endpackage

// File: rtl/idct8_inbuf.sv
module idct8_inbuf
    import idct8_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    output slice_t          slice
);
    localparam int NDIG = IN_W / 2;
    localparam int DW   = $clog2(NDIG);
    localparam int CW   = $clog2(NPT);

    logic [CW-1:0]   wcnt;
    logic [IN_W-1:0] hold [NPT];
    logic [IN_W-1:0] xs   [NPT];
    logic            busy;
    logic [DW-1:0]   dcnt;
    logic            load;

    assign load = in_valid && (wcnt == CW'(NPT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
            busy <= 1'b0;
            dcnt <= '0;
        end else begin
            if (in_valid) wcnt <= wcnt + 1'b1;
            if (load) begin
                busy <= 1'b1;
                dcnt <= '0;
            end else if (busy) begin
                dcnt <= dcnt + 1'b1;
                if (dcnt == DW'(NDIG - 1)) busy <= 1'b0;
            end
        end
    end

    // capture registers, parallel load on the eighth word, then digit shift
    always_ff @(posedge clk) begin
        if (in_valid) hold[wcnt] <= in_data;
        for (int i = 0; i < NPT; i++) begin
            if (load)      xs[i] <= (i == NPT - 1) ? in_data : hold[i];
            else if (busy) xs[i] <= xs[i] << 2;
        end
    end

    always_comb begin
        slice.valid = busy;
        slice.first = (dcnt == '0);
        slice.last  = (dcnt == DW'(NDIG - 1));
        for (int i = 0; i < NPT; i++) slice.d[i] = xs[i][IN_W-1 -: 2];
    end

    // R2: a block needs eight accepted words, so loads never repeat back to back
    a_r2_load_spacing: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);
    // R6: the digit walk stops right after its last digit
    a_r6_walk_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && slice.last) |=> !busy);
    a_r6_digit_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (dcnt < DW'(NDIG)));

endmodule

// File: rtl/idct8_sumnet.sv
module idct8_sumnet
    import idct8_pkg::*;
#(
    parameter int PAR   = 0,   // 0: even coefficients, 1: odd coefficients
    parameter int ACC_W = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  slice_t                  slice,
    output logic signed [ACC_W-1:0] acc [HALF],
    output logic                    done
);
    logic signed [ACC_W-1:0] part [HALF];

    for (genvar n = 0; n < HALF; n++) begin : g_out
        always_comb begin
            int t;
            t = 0;
            for (int m = 0; m < HALF; m++)
                t = t + digit_term(slice.d[2*m+PAR], slice.first, kern_w(2*m+PAR, n));
            part[n] = ACC_W'(t);
        end

        always_ff @(posedge clk) begin
            if (rst)              acc[n] <= '0;
            else if (slice.valid) acc[n] <= (slice.first ? '0 : (acc[n] <<< 2)) + part[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= slice.valid && slice.last;
    end

    // R6: one completion strobe per block
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/idct8_outstage.sv
module idct8_outstage
    import idct8_pkg::*;
#(
    parameter int ACC_W = 30,
    parameter int OUT_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ACC_W-1:0] ev [HALF],
    input  logic signed [ACC_W-1:0] od [HALF],
    input  logic                    done,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);
    localparam int SW = ACC_W + 1;
    localparam int CW = $clog2(NPT);
    localparam logic signed [SW-1:0] RND = SW'(2 ** COEF_FRAC);
    localparam logic signed [SW-1:0] HI  = SW'(2 ** (OUT_W - 1) - 1);
    localparam logic signed [SW-1:0] LO  = SW'(-(2 ** (OUT_W - 1)));

    function automatic logic [OUT_W-1:0] shape(logic signed [SW-1:0] s);
        logic signed [SW-1:0] r;
        r = (s + RND) >>> (COEF_FRAC + 1);
        if (r > HI) return HI[OUT_W-1:0];
        if (r < LO) return LO[OUT_W-1:0];
        return r[OUT_W-1:0];
    endfunction

    logic [OUT_W-1:0] res [NPT];
    logic [CW-1:0]    oidx;

    for (genvar n = 0; n < HALF; n++) begin : g_bfly
        logic signed [SW-1:0] e_x, o_x;
        assign e_x = {ev[n][ACC_W-1], ev[n]};
        assign o_x = {od[n][ACC_W-1], od[n]};
        always_ff @(posedge clk) begin
            if (done) begin
                res[n]         <= shape(e_x + o_x);
                res[NPT-1-n]   <= shape(e_x - o_x);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            oidx      <= '0;
        end else if (done) begin
            out_valid <= 1'b1;
            oidx      <= '0;
        end else if (out_valid) begin
            oidx <= oidx + 1'b1;
            if (oidx == CW'(NPT - 1)) out_valid <= 1'b0;
        end
    end

    assign out_data = out_valid ? res[oidx] : '0;

    // R7: within a block the samples are contiguous and in rising index order
    a_r7_contiguous: assert property (@(posedge clk) disable iff (rst)
        (out_valid && oidx != CW'(NPT - 1)) |=> (out_valid && oidx == $past(oidx) + 1'b1));
    // R7: a new result set lands only when the previous stream is ending
    a_r7_no_overrun: assert property (@(posedge clk) disable iff (rst)
        done |-> (!out_valid || oidx == CW'(NPT - 1)));
    // R3: each stream starts at sample 0
    a_r3_first_index: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (oidx == '0));

endmodule

// File: rtl/idct8_core.sv
module idct8_core
    import idct8_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int ACC_W = IN_W + COEF_FRAC + 4;

    slice_t                  slice;
    logic signed [ACC_W-1:0] ev_acc [HALF];
    logic signed [ACC_W-1:0] od_acc [HALF];
    logic                    ev_done, od_done;

    idct8_inbuf #(.IN_W(IN_W)) u_inbuf (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .slice(slice)
    );

    idct8_sumnet #(.PAR(0), .ACC_W(ACC_W)) u_even (
        .clk(clk), .rst(rst), .slice(slice), .acc(ev_acc), .done(ev_done)
    );

    idct8_sumnet #(.PAR(1), .ACC_W(ACC_W)) u_odd (
        .clk(clk), .rst(rst), .slice(slice), .acc(od_acc), .done(od_done)
    );

    idct8_outstage #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst(rst), .ev(ev_acc), .od(od_acc), .done(ev_done),
        .out_valid(out_valid), .out_data(out_data)
    );

    // R3: the two kernel halves finish in the same cycle
    a_r3_halves_lockstep: assert property (@(posedge clk) disable iff (rst)
        ev_done == od_done);

endmodule

// File: tb/idct8_core_tb.sv
module idct8_core_tb;
    localparam int IN_W  = 12;
    localparam int OUT_W = 13;
    localparam int MAXV  = 4095;
    localparam int MINV  = -4096;
    localparam int NTAB  = 6;

    localparam int STIM [NTAB][8] = '{
        '{400, 0, 0, 0, 0, 0, 0, 0},
        '{0, 300, 0, 0, 0, 0, 0, 0},
        '{-200, 150, -100, 75, -50, 25, -12, 6},
        '{511, -512, 511, -512, 511, -512, 511, -512},
        '{300, 0, -200, 0, 150, 0, -100, 0},
        '{0, 250, 0, -180, 0, 120, 0, -60}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [IN_W-1:0]  in_data = '0;
    logic out_valid;
    logic [OUT_W-1:0] out_data;

    always #5 clk = ~clk;

    idct8_core #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    int  cyc = 0;
    int  nchk = 0;
    int  nfail = 0;
    bit  finished = 1'b0;
    int  blk [8];
    real exp_v [0:2047];
    bit  exact_v [0:2047];
    int  cap [0:2047];
    int  vcyc [0:2047];
    int  wr = 0;
    int  rd = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, int act, int expd);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expd);
        end
    endtask

    function automatic real model(int n);
        real s, pi;
        pi = 3.14159265358979323846;
        s = 0.0;
        for (int k = 0; k < 8; k++)
            s = s + ((k == 0) ? 0.70710678118654752 : 1.0) / 2.0 * blk[k]
                    * $cos((2 * n + 1) * k * pi / 16.0);
        return s * 1.41421356237309505;
    endfunction

    task automatic push_expected(bit exact);
        for (int n = 0; n < 8; n++) begin
            real v;
            v = model(n);
            if (v > MAXV) v = MAXV;
            if (v < MINV) v = MINV;
            exp_v[wr]   = v;
            exact_v[wr] = exact;
            wr++;
        end
    endtask

    task automatic send_word(int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = IN_W'(v);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_blk(bit exact);
        push_expected(exact);
        for (int i = 0; i < 8; i++) send_word(blk[i]);
    endtask

    task automatic drain();
        idle(1);
        while (rd < wr) @(negedge clk);
        idle(2);
    endtask

    // output monitor: R3 accuracy, R4 exact zeros, R5 clamp
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int  got;
            real d;
            string tag;
            got = $signed(out_data);
            cap[rd]  = got;
            vcyc[rd] = cyc;
            if (rd >= wr) begin
                check(1'b0, "R1 unexpected sample", got, 0);
            end else begin
                d = real'(got) - exp_v[rd];
                tag = exact_v[rd] ? "R4" : ((exp_v[rd] >= MAXV || exp_v[rd] <= MINV) ? "R5" : "R3");
                if (exact_v[rd]) check(got == $rtoi(exp_v[rd]), tag, got, $rtoi(exp_v[rd]));
                else             check(d <= 1.0 && d >= -1.0, tag, got, $rtoi(exp_v[rd]));
            end
            rd++;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
        summary();
    end

    initial begin
        int base, t0, t1;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R1 reset", int'(out_valid), 0);
        rst = 1'b0;

        // R2 + R1: seven words with idle gaps produce nothing; eighth completes the block
        blk = '{120, -80, 60, -40, 30, -20, 10, -5};
        push_expected(1'b0);
        for (int i = 0; i < 7; i++) begin
            send_word(blk[i]);
            idle(2);
        end
        idle(12);
        check(rd == 0 && out_valid == 1'b0, "R1 partial block", rd, 0);
        send_word(blk[7]);
        drain();
        check(rd == 8, "R2 gapped block sample count", rd, 8);

        // table of directed blocks, sent back to back
        base = wr;
        for (int b = 0; b < NTAB; b++) begin
            for (int i = 0; i < 8; i++) blk[i] = STIM[b][i];
            send_blk(1'b0);
        end
        drain();
        // R7: continuous stream, 48 samples over 48 consecutive cycles
        check(vcyc[base + NTAB*8 - 1] - vcyc[base] == NTAB*8 - 1, "R7 stream span",
              vcyc[base + NTAB*8 - 1] - vcyc[base], NTAB*8 - 1);
        // R8: even-only block mirror-equal, odd-only block mirror-negated
        for (int n = 0; n < 4; n++) begin
            int a, b2, s;
            a  = cap[base + 32 + n];
            b2 = cap[base + 32 + 7 - n];
            check(a == b2, "R8 even mirror", a, b2);
            a  = cap[base + 40 + n];
            b2 = cap[base + 40 + 7 - n];
            s  = a + b2;
            check(s <= 1 && s >= -1, "R8 odd mirror", a, -b2);
        end

        // R6: latency from the last accepted word
        blk = '{-300, 40, 90, -70, 0, 15, -33, 8};
        send_blk(1'b0);
        idle(1);
        t0 = cyc;
        while (!out_valid) @(negedge clk);
        t1 = cyc;
        check(t1 - t0 == 7, "R6 latency", t1 - t0, 7);
        drain();

        // R4: all-zero block
        blk = '{0, 0, 0, 0, 0, 0, 0, 0};
        send_blk(1'b1);
        drain();

        // R5: saturation at both ends
        base = wr;
        blk = '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047};
        send_blk(1'b0);
        blk = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048};
        send_blk(1'b0);
        drain();
        check(cap[base] == MAXV, "R5 positive clamp", cap[base], MAXV);
        check(cap[base + 8] == MINV, "R5 negative clamp", cap[base + 8], MINV);

        // R3 + R7: random blocks back to back
        for (int b = 0; b < 40; b++) begin
            for (int i = 0; i < 8; i++) blk[i] = int'($urandom_range(1023, 0)) - 512;
            send_blk(1'b0);
        end
        drain();
        check(rd == wr, "R3 total samples", rd, wr);

        summary();
    end

endmodule